// File: doc/BRIEF.md
# Shared-Pin Bidirectional GPIO Port

This block is one eight-pin general-purpose I/O port. Its pins are also used by a synchronous serial link, an asynchronous serial link and two timer capture channels. Software reaches three registers through a small select/strobe register bus. The first is an output data latch. The second is a per-pin direction register. The third is an option register whose bit 0 is a global pull-up enable. The port produces per-pin output-enable, output-value and pull-up-enable vectors for the pad ring, and passes pad levels back to the peripherals.

When a peripheral is switched on, it takes over fixed pins and sets their direction itself. The serial-link pins are bits 4..7: master-in/slave-out on bit 4, master-out/slave-in on bit 5, serial clock on bit 6 and slave select on bit 7. The asynchronous link uses bit 2 for receive and bit 3 for transmit. Bits 0 and 1 feed the two capture channels. Pins that no peripheral claims follow the direction and latch registers.

Top module: `gpio_mux_port`

## Requirements
- R1: With no peripheral enabled, pad_oe bit n equals direction bit n: 1 drives the pin, 0 makes it an input.
- R2: Reset clears the direction register and the option register. It leaves the data latch unchanged, so after reset all pins are inputs and a later read of an output pin returns the latch value written before reset.
- R3: A write to the data register (address 0) always loads the latch. pad_out carries the latch on each pin the port drives, and that value reaches the pin only where pad_oe is 1.
- R4: A read of address 0 returns the pad level for bits whose direction bit is 0, and the latch for bits whose direction bit is 1.
- R5: With the serial link enabled as master, bits 5 and 6 are driven with the link's MOSI and clock outputs, and bits 4 and 7 are inputs, whatever the direction register holds.
- R6: With the serial link enabled as slave, only bit 4 may be driven, with the link's MISO output, and only while the pad level on bit 7 is low. Bits 5..7 are inputs.
- R7: With the asynchronous link enabled, bit 3 is driven with its transmit output and bit 2 is an input, whatever the direction register holds.
- R8: The pad levels on bits 4..7, bit 2 and bits 1..0 are always passed to the serial-link receive inputs, the asynchronous receive input and capture inputs 0 and 1.
- R9: pad_pu bit n is 1 only when the option register's bit 0 is 1 and pin n is not driven.
- R10: Register writes happen at the clock edge where sel and wr are both 1. A cycle with wr low changes nothing. Address 1 reads back the direction register, address 2 reads the option bit in bit 0, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register select |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address (0 data, 1 direction, 2 option) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| spi_en | input | 1 | Serial link enabled |
| spi_master | input | 1 | Serial link is master (1) or slave (0) |
| spi_miso_drv | input | 1 | Slave data out from the serial link |
| spi_mosi_drv | input | 1 | Master data out from the serial link |
| spi_sck_drv | input | 1 | Master clock out from the serial link |
| spi_miso_rcv | output | 1 | Pad level of bit 4 to the serial link |
| spi_mosi_rcv | output | 1 | Pad level of bit 5 to the serial link |
| spi_sck_rcv | output | 1 | Pad level of bit 6 to the serial link |
| spi_ss_rcv | output | 1 | Pad level of bit 7 to the serial link |
| sci_en | input | 1 | Asynchronous link enabled |
| sci_txd_drv | input | 1 | Transmit data from the asynchronous link |
| sci_rxd_rcv | output | 1 | Pad level of bit 2 to the asynchronous link |
| cap_rcv | output | 2 | Pad levels of bits 1..0 to the capture channels |

## Verification
The embedded properties assume that the peripheral enables and the master/slave select are steady, known levels after reset. They also assume that the register bus never raises wr without sel for a write it expects to land. The stimulus changes peripheral modes and pad levels only between register accesses, drives wr only together with sel except in the one case meant to show that it is ignored, and keeps pad_in fully defined at all times. The slave-select gate is exercised with the select pin both high and low while the direction register holds ones on those pins.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int PORT_W  = 8;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_OPT  = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    // fixed pin assignment of the shared functions
    localparam int PIN_CAP0 = 0;
    localparam int PIN_CAP1 = 1;
    localparam int PIN_RXD  = 2;
    localparam int PIN_TXD  = 3;
    localparam int PIN_MISO = 4;
    localparam int PIN_MOSI = 5;
    localparam int PIN_SCK  = 6;
    localparam int PIN_SS   = 7;

    localparam int OPT_PU_BIT = 0;

    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] dout;
    } port_drive_t;

    typedef struct packed {
        logic en;
        logic master;
        logic miso;
        logic mosi;
        logic sck;
    } spi_side_t;

    typedef struct packed {
        logic en;
        logic txd;
    } sci_side_t;

    // Per-bit readback: pad level for inputs, latch for outputs.
    function automatic logic [PORT_W-1:0] merge_read(
        input logic [PORT_W-1:0] dir,
        input logic [PORT_W-1:0] latch,
        input logic [PORT_W-1:0] pad
    );
        return (dir & latch) | (~dir & pad);
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mux_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  latch_q,
    output logic          pu_en_q
);

    logic wr_hit;
    logic data_wr, dir_wr, opt_wr;

    assign wr_hit  = sel && wr;
    assign data_wr = wr_hit && (addr == REG_DATA);
    assign dir_wr  = wr_hit && (addr == REG_DIR);
    assign opt_wr  = wr_hit && (addr == REG_OPT);

    // latch has no reset on purpose
    always_ff @(posedge clk) begin
        if (data_wr)
            latch_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            pu_en_q <= 1'b0;
        end else begin
            if (dir_wr)
                dir_q <= wdata;
            if (opt_wr)
                pu_en_q <= wdata[OPT_PU_BIT];
        end
    end

    p_dir_clear_r2: assert property (@(posedge clk)
        rst |=> (dir_q == '0) && !pu_en_q)
        else $error("direction/option not cleared by reset");

    p_latch_load_r3: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && addr == REG_DATA) |=> latch_q == $past(wdata))
        else $error("data latch did not load");

    p_no_wr_no_change_r10: assert property (@(posedge clk) disable iff (rst)
        !(sel && wr) |=> $stable(dir_q) && $stable(pu_en_q))
        else $error("register changed without strobe");

endmodule

// File: rtl/gpio_alt_mux.sv
module gpio_alt_mux
    import gpio_mux_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] pad_in,
    input  spi_side_t   spi,
    input  sci_side_t   sci,
    output port_drive_t drv
);

    logic [W-1:0] claim;
    logic [W-1:0] alt_oe;
    logic [W-1:0] alt_out;
    logic         slave_sel;

    assign slave_sel = !pad_in[PIN_SS];

    always_comb begin
        claim   = '0;
        alt_oe  = '0;
        alt_out = '0;
        if (spi.en) begin
            claim[PIN_MISO] = 1'b1;
            claim[PIN_MOSI] = 1'b1;
            claim[PIN_SCK]  = 1'b1;
            claim[PIN_SS]   = 1'b1;
            if (spi.master) begin
                alt_oe[PIN_MOSI]  = 1'b1;
                alt_oe[PIN_SCK]   = 1'b1;
                alt_out[PIN_MOSI] = spi.mosi;
                alt_out[PIN_SCK]  = spi.sck;
            end else begin
                alt_oe[PIN_MISO]  = slave_sel;
                alt_out[PIN_MISO] = spi.miso;
            end
        end
        if (sci.en) begin
            claim[PIN_RXD]   = 1'b1;
            claim[PIN_TXD]   = 1'b1;
            alt_oe[PIN_TXD]  = 1'b1;
            alt_out[PIN_TXD] = sci.txd;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (claim[i]) begin
                drv.oe[i]   = alt_oe[i];
                drv.dout[i] = alt_out[i];
            end else begin
                drv.oe[i]   = dir_q[i];
                drv.dout[i] = latch_q[i];
            end
        end
    end

    p_slave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (spi.en && !spi.master && pad_in[PIN_SS]) |-> (drv.oe[PIN_SS:PIN_MISO] == '0))
        else $error("slave drove pins while deselected");

    p_master_dir_r5: assert property (@(posedge clk) disable iff (rst)
        (spi.en && spi.master) |-> drv.oe[PIN_MOSI] && drv.oe[PIN_SCK]
                                   && !drv.oe[PIN_MISO] && !drv.oe[PIN_SS])
        else $error("master pin directions wrong");

    p_sci_dir_r7: assert property (@(posedge clk) disable iff (rst)
        sci.en |-> drv.oe[PIN_TXD] && !drv.oe[PIN_RXD]
                   && (drv.dout[PIN_TXD] == sci.txd))
        else $error("async link pin directions wrong");

endmodule

// File: rtl/gpio_port_readback.sv
module gpio_port_readback
    import gpio_mux_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          sel,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  dir_q,
    input  logic [W-1:0]  latch_q,
    input  logic          pu_en_q,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        if (sel) begin
            unique case (reg_addr_e'(addr))
                REG_DATA: rdata = merge_read(dir_q, latch_q, pad_in);
                REG_DIR:  rdata = dir_q;
                REG_OPT:  rdata[OPT_PU_BIT] = pu_en_q;
                REG_NONE: rdata = '0;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic              spi_miso_drv,
    input  logic              spi_mosi_drv,
    input  logic              spi_sck_drv,
    output logic              spi_miso_rcv,
    output logic              spi_mosi_rcv,
    output logic              spi_sck_rcv,
    output logic              spi_ss_rcv,
    input  logic              sci_en,
    input  logic              sci_txd_drv,
    output logic              sci_rxd_rcv,
    output logic [1:0]        cap_rcv
);

    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] latch_q;
    logic              pu_en_q;
    spi_side_t         spi_s;
    sci_side_t         sci_s;
    port_drive_t       drv;

    assign spi_s = '{en: spi_en, master: spi_master, miso: spi_miso_drv,
                     mosi: spi_mosi_drv, sck: spi_sck_drv};
    assign sci_s = '{en: sci_en, txd: sci_txd_drv};

    gpio_port_regs #(.W(PORT_W), .AW(ADDR_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wr      (wr),
        .addr    (addr),
        .wdata   (wdata),
        .dir_q   (dir_q),
        .latch_q (latch_q),
        .pu_en_q (pu_en_q)
    );

    gpio_alt_mux #(.W(PORT_W)) mux_i (
        .clk     (clk),
        .rst     (rst),
        .dir_q   (dir_q),
        .latch_q (latch_q),
        .pad_in  (pad_in),
        .spi     (spi_s),
        .sci     (sci_s),
        .drv     (drv)
    );

    gpio_port_readback #(.W(PORT_W), .AW(ADDR_W)) rb_i (
        .sel     (sel),
        .addr    (addr),
        .dir_q   (dir_q),
        .latch_q (latch_q),
        .pu_en_q (pu_en_q),
        .pad_in  (pad_in),
        .rdata   (rdata)
    );

    assign pad_oe  = drv.oe;
    assign pad_out = drv.dout;
    assign pad_pu  = {PORT_W{pu_en_q}} & ~drv.oe;

    assign spi_miso_rcv = pad_in[PIN_MISO];
    assign spi_mosi_rcv = pad_in[PIN_MOSI];
    assign spi_sck_rcv  = pad_in[PIN_SCK];
    assign spi_ss_rcv   = pad_in[PIN_SS];
    assign sci_rxd_rcv  = pad_in[PIN_RXD];
    assign cap_rcv      = {pad_in[PIN_CAP1], pad_in[PIN_CAP0]};

    p_pu_off_after_rst_r9: assert property (@(posedge clk)
        rst |=> pad_pu == '0)
        else $error("pull-ups active after reset");

    p_inputs_after_rst_r2: assert property (@(posedge clk)
        (rst && !spi_en && !sci_en) |=> (!spi_en && !sci_en) |-> pad_oe == '0)
        else $error("pins driven after reset");

endmodule

// File: tb/gpio_mux_port_tb_top.sv
module gpio_mux_port_tb_top;

    localparam int S_RDATA = 0;
    localparam int S_OE    = 1;
    localparam int S_OUT   = 2;
    localparam int S_PU    = 3;
    localparam int S_SPI   = 4;
    localparam int S_MISC  = 5;

    typedef struct {
        int         sig;
        logic [7:0] exp;
        logic [7:0] mask;
        string      req;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, pad_in = '0;
    logic       spi_en = 0, spi_master = 0, spi_miso_drv = 0, spi_mosi_drv = 0, spi_sck_drv = 0;
    logic       sci_en = 0, sci_txd_drv = 0;
    logic [7:0] rdata, pad_out, pad_oe, pad_pu;
    logic       spi_miso_rcv, spi_mosi_rcv, spi_sck_rcv, spi_ss_rcv, sci_rxd_rcv;
    logic [1:0] cap_rcv;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;
    sb_item_t sbq[$];

    always #4 clk = ~clk;   // 125 MHz

    gpio_mux_port dut_i (
        .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .spi_en(spi_en), .spi_master(spi_master),
        .spi_miso_drv(spi_miso_drv), .spi_mosi_drv(spi_mosi_drv),
        .spi_sck_drv(spi_sck_drv), .spi_miso_rcv(spi_miso_rcv),
        .spi_mosi_rcv(spi_mosi_rcv), .spi_sck_rcv(spi_sck_rcv),
        .spi_ss_rcv(spi_ss_rcv), .sci_en(sci_en), .sci_txd_drv(sci_txd_drv),
        .sci_rxd_rcv(sci_rxd_rcv), .cap_rcv(cap_rcv)
    );

    function automatic logic [7:0] observe(int sig);
        case (sig)
            S_RDATA: return rdata;
            S_OE:    return pad_oe;
            S_OUT:   return pad_out;
            S_PU:    return pad_pu;
            S_SPI:   return {4'b0, spi_ss_rcv, spi_sck_rcv, spi_mosi_rcv, spi_miso_rcv};
            default: return {5'b0, sci_rxd_rcv, cap_rcv};
        endcase
    endfunction

    // monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            sb_item_t it;
            logic [7:0] act;
            it  = sbq.pop_front();
            act = observe(it.sig) & it.mask;
            n_vec++;
            if (act !== (it.exp & it.mask)) begin
                n_bad++;
                $display("FAIL %s sig=%0d actual=%02h expected=%02h", it.req, it.sig,
                         act, it.exp & it.mask);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic push(int sig, logic [7:0] exp, logic [7:0] mask, string req);
        sb_item_t it;
        it.sig = sig; it.exp = exp; it.mask = mask; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic flush();
        @(negedge clk); #1;
    endtask

    task automatic reg_wr(logic [1:0] a, logic [7:0] d);
        step();
        sel = 1; wr = 1; addr = a; wdata = d;
        step();
        sel = 0; wr = 0;
    endtask

    task automatic reg_rd(logic [1:0] a, logic [7:0] exp, string req);
        step();
        sel = 1; wr = 0; addr = a;
        push(S_RDATA, exp, 8'hFF, req);
        flush();
        sel = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // reset state (R2, R9, R10)
        push(S_OE, 8'h00, 8'hFF, "R2");
        push(S_PU, 8'h00, 8'hFF, "R9");
        flush();
        rst = 0;
        reg_rd(2'd1, 8'h00, "R2");
        reg_rd(2'd2, 8'h00, "R10");

        // R1: direction controls drive
        reg_wr(2'd1, 8'hA5);
        step(); push(S_OE, 8'hA5, 8'hFF, "R1"); flush();

        // R2: latch survives reset
        reg_wr(2'd0, 8'hA5);
        reg_wr(2'd1, 8'hFF);
        step(); push(S_OUT, 8'hA5, 8'hFF, "R3"); flush();
        step(); rst = 1; step(); step(); rst = 0;
        reg_rd(2'd1, 8'h00, "R2");
        step(); push(S_OE, 8'h00, 8'hFF, "R2"); flush();
        reg_wr(2'd1, 8'hFF);
        reg_rd(2'd0, 8'hA5, "R2");

        // R3: latch loads while input, reaches pins only when driven
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'h3C);
        step(); push(S_OE, 8'h00, 8'hFF, "R3"); flush();
        reg_wr(2'd1, 8'h0F);
        step(); push(S_OE, 8'h0F, 8'hFF, "R3"); push(S_OUT, 8'h0C, 8'h0F, "R3"); flush();

        // R4: mixed readback
        pad_in = 8'h96;
        reg_rd(2'd0, 8'h9C, "R4");
        pad_in = 8'h69;
        reg_rd(2'd0, 8'h6C, "R4");

        // R10: strobe without wr ignored, addr 3 reads zero
        step(); sel = 1; wr = 0; addr = 2'd1; wdata = 8'hFF; step(); sel = 0;
        reg_rd(2'd1, 8'h0F, "R10");
        reg_wr(2'd3, 8'hFF);
        reg_rd(2'd3, 8'h00, "R10");
        reg_rd(2'd1, 8'h0F, "R10");

        // R5: master
        reg_wr(2'd1, 8'h90);
        step(); spi_en = 1; spi_master = 1; spi_mosi_drv = 1; spi_sck_drv = 0;
        pad_in = 8'h90;
        push(S_OE, 8'h60, 8'hF0, "R5"); push(S_OUT, 8'h20, 8'h60, "R5");
        push(S_SPI, 8'h09, 8'hFF, "R8"); flush();
        step(); spi_mosi_drv = 0; spi_sck_drv = 1;
        push(S_OUT, 8'h40, 8'h60, "R5"); flush();

        // R6: slave, select high then low
        reg_wr(2'd1, 8'hF0);
        step(); spi_master = 0; spi_miso_drv = 1; pad_in = 8'h80;
        push(S_OE, 8'h00, 8'hF0, "R6"); flush();
        step(); pad_in = 8'h00;
        push(S_OE, 8'h10, 8'hF0, "R6"); push(S_OUT, 8'h10, 8'h10, "R6"); flush();
        step(); spi_miso_drv = 0;
        push(S_OUT, 8'h00, 8'h10, "R6"); flush();
        step(); spi_en = 0;
        push(S_OE, 8'hF0, 8'hF0, "R1"); flush();

        // R7: async link, direction register inverted on its pins
        reg_wr(2'd1, 8'h04);
        step(); sci_en = 1; sci_txd_drv = 1; pad_in = 8'h04;
        push(S_OE, 8'h08, 8'h0C, "R7"); push(S_OUT, 8'h08, 8'h08, "R7");
        push(S_MISC, 8'h04, 8'h04, "R8"); flush();
        step(); sci_txd_drv = 0;
        push(S_OUT, 8'h00, 8'h08, "R7"); flush();

        // R8: capture inputs follow pads
        step(); pad_in = 8'h02; push(S_MISC, 8'h02, 8'h07, "R8"); flush();
        step(); pad_in = 8'h01; push(S_MISC, 8'h01, 8'h07, "R8"); flush();

        // R9: pull-ups on undriven pins only
        reg_wr(2'd2, 8'h01);
        reg_rd(2'd2, 8'h01, "R10");
        step(); push(S_PU, 8'hF7, 8'hFF, "R9"); flush();
        step(); sci_en = 0; push(S_PU, 8'hFB, 8'hFF, "R9"); flush();
        reg_wr(2'd1, 8'h0F);
        step(); push(S_PU, 8'hF0, 8'hFF, "R9"); flush();
        reg_wr(2'd2, 8'h00);
        step(); push(S_PU, 8'h00, 8'hFF, "R9"); flush();

        step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule